// File: doc/BRIEF.md
# Split-Mode Auto-Reload Timer with Capture

This block is a timer that runs as either a single 16-bit up-counter or as two independent 8-bit up-counters. Each counter reloads from its own reload register when it rolls over. Each byte has a sticky overflow flag. The flags, a low-byte interrupt enable and a global enable combine into one interrupt request. A capture path watches a slow asynchronous reference clock. On each falling edge of that clock, while capture is armed, it copies the live 16-bit count into the reload pair and pulses the interrupt request.

Software reaches the block through a write port and a combinational read port. There are five locations: 0 is control, 1 is count low, 2 is count high, 3 is reload low and 4 is reload high. Address 7 and other unused addresses read zero.

The count tick is chosen per byte. It is either the system-clock enable itself or a prescaled tick. The prescaled tick is the system-clock enable divided by 12, or the rising edges of an external clock divided by 8 after synchronisation.

Control byte fields, with positions:
- bit7: upper overflow flag
- bit6: lower overflow flag
- bit5: lower interrupt enable
- bit4: capture enable
- bit3: split select
- bit2: run
- bit1: unused
- bit0: prescale source, where 1 selects the external clock

Top module: `split_reload_timer`

## Requirements
- R1: After reset, all five locations read 0x00 and `irq` is low.
- R2: Control bit1 always reads 0 and ignores writes. All other control bits read back as written when no hardware event occurs.
- R3: With split=0 and run=1, each low-byte tick adds one to the 16-bit count. On the tick at 0xFFFF, the count loads {reload high, reload low} and both overflow flags (bit7 and bit6) set.
- R4: In 16-bit mode, a low-byte wrap without a full wrap (for example 0x12FF to 0x1300) sets bit6 only.
- R5: With split=1, the low byte counts on its tick whatever the run bit says. At 0xFF it loads reload low and sets bit6. The high byte holds while run=0.
- R6: With split=1 and run=1, the high byte counts on its tick. At 0xFF it loads reload high and sets bit7.
- R7: Overflow flags are never cleared by hardware. A control write clears them, except in a cycle where the matching wrap also occurs; in that cycle the flag stays set.
- R8: `irq` = `glb_irq_en` AND (bit7 OR (bit6 AND bit5) OR capture pulse).
- R9: With bit4=1, a falling edge on `slow_ref` copies the live count into the reload pair on the third rising clock edge after the input changes. `irq` is high for the one cycle before that edge when `glb_irq_en`=1. With bit4=0, a falling edge has no effect.
- R10: While bit4=1, a rollover goes to zero instead of loading the reload value. Flags still set.
- R11: With `lo_use_sysclk`=0, the low byte ticks on every 12th `sys_ce` pulse when bit0=0. When bit0=1, it ticks on every 8th rising edge of `ext_clk`. With `lo_use_sysclk`=1, it ticks on every `sys_ce` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write location |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read location |
| rd_data | output | 8 | Read data (combinational) |
| sys_ce | input | 1 | System-clock count enable |
| ext_clk | input | 1 | Asynchronous external clock |
| lo_use_sysclk | input | 1 | Low byte ticks on `sys_ce` instead of prescaled tick |
| hi_use_sysclk | input | 1 | High byte ticks on `sys_ce` instead of prescaled tick (split mode) |
| slow_ref | input | 1 | Asynchronous slow reference clock for capture |
| glb_irq_en | input | 1 | Global timer interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Counter and flag updates are registered. A write or tick presented in one cycle is visible on `rd_data` after the next rising edge, and the bench reads it at the following falling edge. `irq` follows the flag registers with no further delay. A capture passes two synchronizer stages and an edge-detect stage. Its `irq` pulse is therefore sampled at the falling edge after the second rising edge following the change on `slow_ref`, and the reload pair one edge later. The prescaled paths are checked by counting input events, 12 per tick or 8 rising edges per tick, and reading the count only after the synchronizer has settled.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_RLD_LO = 3'd3,
    A_RLD_HI = 3'd4
  } reg_addr_e;

  // control byte bit positions
  localparam int B_HI_OVF  = 7;
  localparam int B_LO_OVF  = 6;
  localparam int B_LO_IEN  = 5;
  localparam int B_CAP_EN  = 4;
  localparam int B_SPLIT   = 3;
  localparam int B_RUN     = 2;
  localparam int B_EXT_SEL = 0;
endpackage

// File: rtl/srt_edge_sync.sv
module srt_edge_sync #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_pulse
);
  logic [STAGES:0] sh_q, sh_d;
  logic            sync_lvl, prev_lvl;

  always_comb sh_d = {sh_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sync_lvl = sh_q[STAGES-1];
  assign prev_lvl = sh_q[STAGES];

  generate
    if (FALLING) begin : g_fall
      assign edge_pulse = prev_lvl & ~sync_lvl;
    end else begin : g_rise
      assign edge_pulse = sync_lvl & ~prev_lvl;
    end
  endgenerate

  // R9 / R11: an edge pulse never lasts two cycles
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse);
endmodule

// File: rtl/srt_pulse_div.sv
module srt_pulse_div #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pulse,
  output logic out_pulse
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last   = (cnt_q == LAST);
  assign out_pulse = in_pulse & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (in_pulse) cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R11: the prescale phase stays inside its modulus
  a_r11_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
  import srt_pkg::*;
#(
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              sys_ce,
  input  logic              ext_clk,
  input  logic              lo_use_sysclk,
  input  logic              hi_use_sysclk,
  input  logic              slow_ref,
  input  logic              glb_irq_en,
  output logic              irq
);
  // ---------------- tick sources ----------------
  logic sys_tick, ext_rise, ext_tick, ref_fall;

  srt_pulse_div #(.DIV(SYS_DIV)) u_sys_div (
    .clk(clk), .rst_n(rst_n), .in_pulse(sys_ce), .out_pulse(sys_tick));

  srt_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .edge_pulse(ext_rise));

  srt_pulse_div #(.DIV(EXT_DIV)) u_ext_div (
    .clk(clk), .rst_n(rst_n), .in_pulse(ext_rise), .out_pulse(ext_tick));

  srt_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .async_in(slow_ref), .edge_pulse(ref_fall));

  // ---------------- state ----------------
  logic hi_ovf_q, lo_ovf_q, lo_ien_q, cap_en_q, split_q, run_q, ext_sel_q;
  logic hi_ovf_d, lo_ovf_d, lo_ien_d, cap_en_d, split_d, run_d, ext_sel_d;
  logic [BYTE_W-1:0] cnt_lo_q, cnt_hi_q, rld_lo_q, rld_hi_q;
  logic [BYTE_W-1:0] cnt_lo_d, cnt_hi_d, rld_lo_d, rld_hi_d;

  // ---------------- next state ----------------
  logic pre_tick, lo_tick, hi_tick;
  logic ctrl_wr, cnt_lo_wr, cnt_hi_wr, rld_lo_wr, rld_hi_wr, cnt_wr;
  logic lo_max, hi_max, lo_step, hi_step, lo_wrap, hi_wrap, lo_reload_now;
  logic cap_fire;

  assign pre_tick = ext_sel_q ? ext_tick : sys_tick;
  assign lo_tick  = lo_use_sysclk ? sys_ce : pre_tick;
  assign hi_tick  = hi_use_sysclk ? sys_ce : pre_tick;

  assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  assign cnt_lo_wr = wr_en && (wr_addr == A_CNT_LO);
  assign cnt_hi_wr = wr_en && (wr_addr == A_CNT_HI);
  assign rld_lo_wr = wr_en && (wr_addr == A_RLD_LO);
  assign rld_hi_wr = wr_en && (wr_addr == A_RLD_HI);
  assign cnt_wr    = cnt_lo_wr | cnt_hi_wr;

  assign lo_max = (cnt_lo_q == '1);
  assign hi_max = (cnt_hi_q == '1);

  always_comb begin
    if (split_q) begin
      lo_step = lo_tick && !cnt_wr;
      hi_step = run_q && hi_tick && !cnt_wr;
    end else begin
      lo_step = run_q && lo_tick && !cnt_wr;
      hi_step = lo_step && lo_max;
    end
  end

  assign lo_wrap       = lo_step && lo_max;
  assign hi_wrap       = hi_step && hi_max;
  assign lo_reload_now = split_q ? lo_wrap : hi_wrap;
  assign cap_fire      = cap_en_q && ref_fall;

  always_comb begin
    cnt_lo_d = cnt_lo_q;
    if (cnt_lo_wr)    cnt_lo_d = wr_data;
    else if (lo_step) cnt_lo_d = !lo_max ? cnt_lo_q + 1'b1
                               : (lo_reload_now && !cap_en_q) ? rld_lo_q : '0;

    cnt_hi_d = cnt_hi_q;
    if (cnt_hi_wr)    cnt_hi_d = wr_data;
    else if (hi_step) cnt_hi_d = !hi_max ? cnt_hi_q + 1'b1
                               : !cap_en_q ? rld_hi_q : '0;

    rld_lo_d = rld_lo_q;
    rld_hi_d = rld_hi_q;
    if (cap_fire) begin
      rld_lo_d = cnt_lo_q;
      rld_hi_d = cnt_hi_q;
    end else begin
      if (rld_lo_wr) rld_lo_d = wr_data;
      if (rld_hi_wr) rld_hi_d = wr_data;
    end

    hi_ovf_d  = hi_wrap ? 1'b1 : ctrl_wr ? wr_data[B_HI_OVF] : hi_ovf_q;
    lo_ovf_d  = lo_wrap ? 1'b1 : ctrl_wr ? wr_data[B_LO_OVF] : lo_ovf_q;
    lo_ien_d  = ctrl_wr ? wr_data[B_LO_IEN]  : lo_ien_q;
    cap_en_d  = ctrl_wr ? wr_data[B_CAP_EN]  : cap_en_q;
    split_d   = ctrl_wr ? wr_data[B_SPLIT]   : split_q;
    run_d     = ctrl_wr ? wr_data[B_RUN]     : run_q;
    ext_sel_d = ctrl_wr ? wr_data[B_EXT_SEL] : ext_sel_q;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ovf_q <= 1'b0; lo_ovf_q <= 1'b0; lo_ien_q <= 1'b0; cap_en_q <= 1'b0;
      split_q  <= 1'b0; run_q    <= 1'b0; ext_sel_q <= 1'b0;
      cnt_lo_q <= '0; cnt_hi_q <= '0; rld_lo_q <= '0; rld_hi_q <= '0;
    end else begin
      hi_ovf_q <= hi_ovf_d; lo_ovf_q <= lo_ovf_d; lo_ien_q <= lo_ien_d;
      cap_en_q <= cap_en_d; split_q  <= split_d;  run_q    <= run_d;
      ext_sel_q <= ext_sel_d;
      cnt_lo_q <= cnt_lo_d; cnt_hi_q <= cnt_hi_d;
      rld_lo_q <= rld_lo_d; rld_hi_q <= rld_hi_d;
    end
  end

  // ---------------- outputs ----------------
  assign irq = glb_irq_en && (hi_ovf_q || (lo_ovf_q && lo_ien_q) || cap_fire);

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = {hi_ovf_q, lo_ovf_q, lo_ien_q, cap_en_q,
                           split_q, run_q, 1'b0, ext_sel_q};
      A_CNT_LO: rd_data = cnt_lo_q;
      A_CNT_HI: rd_data = cnt_hi_q;
      A_RLD_LO: rd_data = rld_lo_q;
      A_RLD_HI: rd_data = rld_hi_q;
      default:  rd_data = '0;
    endcase
  end

  // ---------------- assertions ----------------
  a_r3_full_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_q && run_q && lo_tick && !cnt_wr && lo_max && hi_max && !cap_en_q)
    |=> ({cnt_hi_q, cnt_lo_q} == $past({rld_hi_q, rld_lo_q})));

  a_r5_lo_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    (split_q && lo_tick && !cnt_wr && !lo_max)
    |=> (cnt_lo_q == $past(cnt_lo_q) + 8'd1));

  a_r6_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (split_q && !run_q && !cnt_wr) |=> $stable(cnt_hi_q));

  a_r7_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_ovf_q && !ctrl_wr) |=> hi_ovf_q);

  a_r7_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_ovf_q && !ctrl_wr) |=> lo_ovf_q);

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_irq_en |-> !irq);

  a_r9_capture_copy: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> ({rld_hi_q, rld_lo_q} == $past({cnt_hi_q, cnt_lo_q})));

  a_r10_zero_on_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en_q && hi_wrap) |=> (cnt_hi_q == '0));
endmodule

// File: tb/test_split_reload_timer.sv
`timescale 1ns/1ps
module test_split_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic       sys_ce, ext_clk, lo_use_sysclk, hi_use_sysclk, slow_ref, glb_irq_en;
  logic       irq;

  always #2.5 clk = ~clk;

  split_reload_timer i_split_reload_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sys_ce(sys_ce), .ext_clk(ext_clk),
    .lo_use_sysclk(lo_use_sysclk), .hi_use_sysclk(hi_use_sysclk),
    .slow_ref(slow_ref), .glb_irq_en(glb_irq_en), .irq(irq));

  typedef struct {
    string      req;
    logic [2:0] addr;   // 7 means the irq port
    logic [7:0] val;
  } item_t;

  item_t q[$];
  int issued = 0, served = 0, checks = 0, errors = 0;
  bit done = 0;

  // monitor: pops expected items and compares at falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        rd_addr = it.addr;
        #1;
        act = (it.addr == 3'd7) ? {7'b0, irq} : rd_data;
        checks++;
        if (act !== it.val) begin
          errors++;
          $display("FAIL %s addr=%0d actual=%02h expected=%02h", it.req, it.addr, act, it.val);
        end
        served++;
      end
    end
  end

  task automatic expect_val(input string req, input logic [2:0] addr, input logic [7:0] val);
    item_t it;
    it.req = req; it.addr = addr; it.val = val;
    q.push_back(it);
    issued++;
    wait (served == issued);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk); sys_ce = 1'b1;
    repeat (n) @(negedge clk);
    sys_ce = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    sys_ce = 0; ext_clk = 0; lo_use_sysclk = 1; hi_use_sysclk = 1;
    slow_ref = 1; glb_irq_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) expect_val("R1", 3'(a), 8'h00);
    expect_val("R1 irq", 3'd7, 8'h00);

    // R2 bit1 unused
    wr(3'd0, 8'h23); expect_val("R2", 3'd0, 8'h21);
    wr(3'd0, 8'h00); expect_val("R2", 3'd0, 8'h00);

    // R11 prescale from system enable, then from external clock
    lo_use_sysclk = 0;
    wr(3'd0, 8'h04);
    tick(24); expect_val("R11 div12", 3'd1, 8'h02);
    tick(11); expect_val("R11 div12 partial", 3'd1, 8'h02);
    tick(1);  expect_val("R11 div12 edge", 3'd1, 8'h03);
    wr(3'd0, 8'h05);
    for (int i = 0; i < 16; i++) begin
      repeat (4) @(negedge clk); ext_clk = 1;
      repeat (4) @(negedge clk); ext_clk = 0;
    end
    repeat (6) @(negedge clk);
    expect_val("R11 ext div8", 3'd1, 8'h05);
    wr(3'd0, 8'h00);
    lo_use_sysclk = 1;

    // R3 16-bit rollover with reload, both flags
    wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    wr(3'd1, 8'hFD); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h04);
    tick(2);
    expect_val("R3 pre lo", 3'd1, 8'hFF);
    expect_val("R3 pre ctrl", 3'd0, 8'h04);
    tick(1);
    expect_val("R3 lo", 3'd1, 8'h34);
    expect_val("R3 hi", 3'd2, 8'h12);
    expect_val("R3 flags", 3'd0, 8'hC4);

    // R7 write clears, hardware set wins when simultaneous
    wr(3'd0, 8'h04); expect_val("R7 clear", 3'd0, 8'h04);
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    @(negedge clk); sys_ce = 1; wr_en = 1; wr_addr = 3'd0; wr_data = 8'h04;
    @(negedge clk); sys_ce = 0; wr_en = 0;
    expect_val("R7 hw wins", 3'd0, 8'hC4);
    expect_val("R7 count", 3'd1, 8'h34);
    tick(2);
    expect_val("R7 sticky", 3'd0, 8'hC4);
    wr(3'd0, 8'h04);

    // R4 low-byte wrap only
    wr(3'd1, 8'hFF); wr(3'd2, 8'h12);
    tick(1);
    expect_val("R4 lo", 3'd1, 8'h00);
    expect_val("R4 hi", 3'd2, 8'h13);
    expect_val("R4 flags", 3'd0, 8'h44);

    // R8 interrupt combination
    glb_irq_en = 1;
    expect_val("R8 lo no ien", 3'd7, 8'h00);
    wr(3'd0, 8'h64); expect_val("R8 lo ien", 3'd7, 8'h01);
    @(negedge clk); glb_irq_en = 0;
    expect_val("R8 global off", 3'd7, 8'h00);
    @(negedge clk); glb_irq_en = 1;
    wr(3'd0, 8'h84); expect_val("R8 hi flag", 3'd7, 8'h01);
    wr(3'd0, 8'h00); expect_val("R8 cleared", 3'd7, 8'h00);

    // R5 split, run off: low counts, high holds
    wr(3'd3, 8'h80); wr(3'd1, 8'hFE); wr(3'd2, 8'h50);
    wr(3'd0, 8'h08);
    tick(3);
    expect_val("R5 lo", 3'd1, 8'h81);
    expect_val("R5 hi hold", 3'd2, 8'h50);
    expect_val("R5 flags", 3'd0, 8'h48);

    // R6 split, run on: high counts and reloads
    wr(3'd0, 8'h0C); wr(3'd2, 8'hFE);
    tick(3);
    expect_val("R6 hi", 3'd2, 8'h13);
    expect_val("R6 lo", 3'd1, 8'h84);
    expect_val("R6 flags", 3'd0, 8'h8C);

    // R9 capture on falling edge of slow_ref
    wr(3'd0, 8'h10);
    wr(3'd1, 8'h9A); wr(3'd2, 8'h78);
    expect_val("R9 irq idle", 3'd7, 8'h00);
    @(negedge clk); slow_ref = 0;
    @(posedge clk); @(posedge clk);
    expect_val("R9 irq pulse", 3'd7, 8'h01);
    expect_val("R9 rld lo", 3'd3, 8'h9A);
    expect_val("R9 rld hi", 3'd4, 8'h78);
    expect_val("R9 irq after", 3'd7, 8'h00);
    // capture disabled: edge ignored
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h11); wr(3'd2, 8'h11);
    @(negedge clk); slow_ref = 1;
    repeat (5) @(negedge clk); slow_ref = 0;
    repeat (5) @(negedge clk);
    expect_val("R9 disabled lo", 3'd3, 8'h9A);
    expect_val("R9 disabled hi", 3'd4, 8'h78);

    // R10 capture armed: rollover goes to zero
    wr(3'd0, 8'h14);
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    tick(1);
    expect_val("R10 lo", 3'd1, 8'h00);
    expect_val("R10 hi", 3'd2, 8'h00);
    expect_val("R10 flags", 3'd0, 8'hD4);

    done = 1;
    finish_run();
  end
endmodule